// File: doc/BRIEF.md
# Masked Control Register File

This block holds a small set of 64-bit processor control registers behind one indexed read port and one indexed write port. Each index has a fixed write rule. Some registers take the full word. Others keep only a field and zero the other bits. Two registers clear on any write. One register accepts a single write after reset. Two indices are commands that store nothing and raise a one-cycle pulse. Reads are combinational from the index. Writes land on the rising clock edge.

One index is a cycle counter. Its upper half is stored and written by software. Its lower half is a live count of the clock cycles since reset was released. A speculation input blocks every write while it is high. Bad accesses return zero and raise an error pulse. A bad access is a read of a command index, a write to a read-only index, a write to an index that is already locked, or any unused index.

Top module: `ctlreg_file`

## Requirements
- R1: During and after reset, every index reads zero, with two exceptions. Index 5 (memory control) reads 0x6. Index 4 (trap-vector base) reads the parameter TVEC_RESET.
- R2: Indices 0-3 (scratch), 4, 5 and the stored upper half of index 16 take all 64 written bits. A write shows on a read in the cycle after the clock edge.
- R3: A write to index 6 (exception return address) stores the data with bit 1 forced to zero.
- R4: Some writes keep only one field, and the other bits read back as zero:
  - indices 7 and 8 (trap request and enable) keep bits 3:0;
  - indices 9 and 10 (mode) keep bits 4:3, mask 0x18;
  - index 11 (page-table base) keeps bits 63:30;
  - indices 12 and 13 (cache and miss-buffer mode) keep bits 5:0.
- R5: A write of any data to index 14 (exception summary) or index 15 (exception mask) leaves that register at zero.
- R6: A read of index 16 (cycle counter) returns the stored bits 63:32 as its upper half. Its lower half is the number of rising edges since reset was released, modulo 2^32.
- R7: The first write to index 17 (counter control) after reset sets it to 1, whatever the data. Any later write leaves it at 1 and counts as an error.
- R8: While spec is high, a write changes no register, raises no command pulse and raises no error.
- R9: The following accesses return rd_data zero and drive err high for exactly the one cycle after the clock edge:
  - a read of index 19 or 20;
  - a write to index 18 (read-only, reads zero);
  - a write under R7 to index 17 when it is already locked;
  - an access to any index from 21 to 63.
- R10: A write to index 19 or 20 without spec drives cmd_pulse bit 0 or bit 1 high for exactly the one cycle after the clock edge. It stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read access this cycle |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Combinational read data, zero when idle or bad |
| wr_en | input | 1 | Write access this cycle |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| spec | input | 1 | Speculative: suppress writes |
| err | output | 1 | One-cycle error pulse |
| cmd_pulse | output | 2 | One-cycle pulses for command indices 19 and 20 |

## Verification
A wrong mask or write kind in one slot stays hidden until that index is read back. The bench therefore follows every write with reads of random indices, and a corrupted field shows on the very next read of that index. A lower counter half that drifts, stalls or is not tied to reset release shows as a mismatch on any read of index 16. An error or command pulse that is late, stretched or missing shows one cycle after the offending edge. A lock on index 17 that never engages or never releases across reset shows as a missing or spurious err on its second write.

// File: rtl/ctlreg_pkg.sv
// Shared constants, slot indices, write kinds and write masks for the
// control register file. Assumes slots above NSLOT-1 are unused.
package ctlreg_pkg;

    localparam int DATA_W = 64;
    localparam int IDX_W  = 6;
    localparam int NSLOT  = 21;
    localparam int NCMD   = 2;
    localparam int HALF_W = DATA_W / 2;

    localparam int SLOT_SCR0   = 0;
    localparam int SLOT_TVEC   = 4;
    localparam int SLOT_MEMCTL = 5;
    localparam int SLOT_EXCPC  = 6;
    localparam int SLOT_TRQ    = 7;
    localparam int SLOT_TEN    = 8;
    localparam int SLOT_MODEI  = 9;
    localparam int SLOT_MODED  = 10;
    localparam int SLOT_PTBASE = 11;
    localparam int SLOT_CMODE  = 12;
    localparam int SLOT_MMODE  = 13;
    localparam int SLOT_EXCSUM = 14;
    localparam int SLOT_EXCMSK = 15;
    localparam int SLOT_CYCCNT = 16;
    localparam int SLOT_CYCCTL = 17;
    localparam int SLOT_IRQID  = 18;
    localparam int SLOT_CMD0   = 19;

    localparam logic [DATA_W-1:0] MEMCTL_RESET = 64'h6;

    typedef enum logic [2:0] {
        K_NONE, K_RW, K_CLR, K_ONCE, K_RO, K_CMD
    } kind_e;

    // Write kind of each slot index.
    function automatic kind_e kind_of(input int i);
        if (i < 0 || i >= NSLOT)                     return K_NONE;
        if (i == SLOT_EXCSUM || i == SLOT_EXCMSK)     return K_CLR;
        if (i == SLOT_CYCCTL)                         return K_ONCE;
        if (i == SLOT_IRQID)                          return K_RO;
        if (i >= SLOT_CMD0 && i < SLOT_CMD0 + NCMD)   return K_CMD;
        return K_RW;
    endfunction

    // Bits a plain write keeps in each slot.
    function automatic logic [DATA_W-1:0] mask_of(input int i);
        case (i)
            SLOT_EXCPC:                return ~64'h2;
            SLOT_TRQ,   SLOT_TEN:      return 64'hF;
            SLOT_MODEI, SLOT_MODED:    return 64'h18;
            SLOT_PTBASE:               return 64'hFFFF_FFFF_C000_0000;
            SLOT_CMODE, SLOT_MMODE:    return 64'h3F;
            default:                   return '1;
        endcase
    endfunction

endpackage

// File: rtl/ctlreg_cycle.sv
// Free-running cycle count. Counts rising edges since rst_n was released.
// Assumes wraparound at 2^W is acceptable.
module ctlreg_cycle #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    // Advance the count on every edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + W'(1);
    end

endmodule

// File: rtl/ctlreg_decode.sv
// Maps an access index to its write kind. Indices past the bank decode
// as K_NONE. Purely combinational.
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [IW-1:0] idx,
    output kind_e         kind
);

    // Look up the kind of the addressed slot.
    always_comb kind = kind_of(int'(idx));

endmodule

// File: rtl/ctlreg_store.sv
// Storage for every slot. Each slot applies its own rule on a qualified
// write: masked store, clear, or set-once. Slots without storage read zero.
// Assumes we is already qualified by speculation and error checks.
module ctlreg_store
    import ctlreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] TVEC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q [NSLOT]
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam kind_e             KND  = kind_of(g);
        localparam logic [DATA_W-1:0] MSK  = mask_of(g);
        localparam logic [DATA_W-1:0] RSTV = (g == SLOT_TVEC)   ? TVEC_RESET :
                                             (g == SLOT_MEMCTL) ? MEMCTL_RESET : '0;
        if (KND == K_RW || KND == K_CLR || KND == K_ONCE) begin : g_reg
            logic hit;
            assign hit = we && (widx == IDX_W'(g));
            // Hold the slot value and apply its write rule.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[g] <= RSTV;
                end else if (hit) begin
                    if (KND == K_CLR)       q[g] <= '0;
                    else if (KND == K_ONCE) q[g] <= DATA_W'(1);
                    else                    q[g] <= wdata & MSK;
                end
            end
        end else begin : g_none
            assign q[g] = '0;
        end
    end

endmodule

// File: rtl/ctlreg_cmd.sv
// One-cycle command pulses, one per command slot, registered from the
// qualified write. Assumes fire is already qualified by speculation.
module ctlreg_cmd
    import ctlreg_pkg::*;
#(
    parameter int N    = NCMD,
    parameter int BASE = SLOT_CMD0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     pulse
);

    for (genvar k = 0; k < N; k++) begin : g_pulse
        // Raise bit k for one cycle after a write to slot BASE+k.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse[k] <= 1'b0;
            else        pulse[k] <= fire && (idx == IDX_W'(BASE + k));
        end
    end

endmodule

// File: rtl/ctlreg_file.sv
// Masked control register file: combinational indexed read, clocked
// indexed write with per-slot rules, live cycle counter low half, write
// suppression under speculation, registered one-cycle error pulse.
// Assumes one read and one write per cycle. A read of the slot being
// written returns the old value.
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter logic [63:0] TVEC_RESET = 64'h0000_0000_0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [5:0]  rd_idx,
    output logic [63:0] rd_data,
    input  logic        wr_en,
    input  logic [5:0]  wr_idx,
    input  logic [63:0] wr_data,
    input  logic        spec,
    output logic        err,
    output logic [1:0]  cmd_pulse
);

    localparam int SLOT_W = $clog2(NSLOT);

    kind_e             rkind, wkind;
    logic [DATA_W-1:0] q [NSLOT];
    logic [HALF_W-1:0] live;
    logic              wr_live, wr_bad, rd_bad, store_we, cmd_fire;

    ctlreg_decode u_rdec (.idx(rd_idx), .kind(rkind));
    ctlreg_decode u_wdec (.idx(wr_idx), .kind(wkind));

    ctlreg_cycle #(.W(HALF_W)) u_cyc (.clk(clk), .rst_n(rst_n), .count(live));

    // Qualify the write and classify both accesses.
    always_comb begin
        wr_live  = wr_en && !spec;
        wr_bad   = (wkind == K_NONE) || (wkind == K_RO) ||
                   ((wkind == K_ONCE) && q[SLOT_CYCCTL][0]);
        rd_bad   = (rkind == K_NONE) || (rkind == K_CMD);
        store_we = wr_live && !wr_bad;
        cmd_fire = wr_live && (wkind == K_CMD);
    end

    ctlreg_store #(.TVEC_RESET(TVEC_RESET)) u_store (
        .clk(clk), .rst_n(rst_n), .we(store_we),
        .widx(wr_idx), .wdata(wr_data), .q(q)
    );

    ctlreg_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .fire(cmd_fire),
        .idx(wr_idx), .pulse(cmd_pulse)
    );

    // Select read data, merging the live count into the counter slot.
    always_comb begin
        rd_data = '0;
        if (rd_en && !rd_bad) begin
            if (rd_idx == IDX_W'(SLOT_CYCCNT))
                rd_data = {q[SLOT_CYCCNT][DATA_W-1:HALF_W], live};
            else
                rd_data = q[rd_idx[SLOT_W-1:0]];
        end
    end

    // Register the error pulse for bad reads and bad live writes.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (rd_en && rd_bad) || (wr_live && wr_bad);
    end

endmodule

// File: rtl/ctlreg_file_chk.sv
// Port-level properties of ctlreg_file, attached with bind.
module ctlreg_file_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [5:0]  rd_idx,
    input logic [63:0] rd_data,
    input logic        wr_en,
    input logic [5:0]  wr_idx,
    input logic        spec,
    input logic        err,
    input logic [1:0]  cmd_pulse
);

    assert_excpc_bit1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == 6'd6) |-> (rd_data[1] == 1'b0));

    assert_mode_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_idx == 6'd9 || rd_idx == 6'd10)) |-> ((rd_data & ~64'h18) == 64'h0));

    assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !spec && wr_idx == 6'd14) |=> !(rd_en && rd_idx == 6'd14 && rd_data != 64'h0));

    assert_live_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == 6'd16) |=>
        ((rd_en && rd_idx == 6'd16) -> (rd_data[31:0] == $past(rd_data[31:0]) + 32'd1)));

    assert_spec_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && spec && !rd_en) |=> (!err && cmd_pulse == 2'b00));

    assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx >= 6'd19) |-> (rd_data == 64'h0));

    assert_pulse_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse));

    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse[0] |-> $past(wr_en && !spec && wr_idx == 6'd19));

endmodule

bind ctlreg_file ctlreg_file_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .spec(spec),
    .err(err), .cmd_pulse(cmd_pulse)
);

// File: tb/test_ctlreg_file.sv
module test_ctlreg_file;

    localparam logic [63:0] TVEC = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, spec = 1'b0;
    logic [5:0]  rd_idx = '0, wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        err;
    logic [1:0]  cmd_pulse;

    int total = 0, bad = 0;
    logic [63:0] mdl [0:20];
    logic [31:0] bcyc;
    logic        exp_err;
    logic [1:0]  exp_pulse;

    ctlreg_file #(.TVEC_RESET(TVEC)) i_ctlreg_file (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .spec(spec), .err(err), .cmd_pulse(cmd_pulse)
    );

    always #5 clk = ~clk;

    // R6: edges since reset release
    always_ff @(posedge clk) bcyc <= !rst_n ? 32'd0 : bcyc + 32'd1;

    initial begin
        #(10 * 200000);
        $display("FAIL watchdog: run did not end (expected completion)");
        bad++; total++;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [63:0] reset_val(input int i);
        if (i == 4) return TVEC;
        if (i == 5) return 64'h6;
        return 64'h0;
    endfunction

    function automatic logic rd_is_bad(input int i);
        return (i >= 19);
    endfunction

    function automatic logic wr_is_bad(input int i);
        return (i == 18) || (i >= 21) || (i == 17 && mdl[17] == 64'h1);
    endfunction

    // R2-R5, R7: value a slot holds after a good write
    function automatic logic [63:0] after_write(input int i, input logic [63:0] v, input logic [63:0] old);
        case (i)
            0, 1, 2, 3, 4, 5, 16: return v;
            6:       return v & ~64'h2;
            7, 8:    return v & 64'hF;
            9, 10:   return v & 64'h18;
            11:      return v & 64'hFFFF_FFFF_C000_0000;
            12, 13:  return v & 64'h3F;
            14, 15:  return 64'h0;
            17:      return 64'h1;
            default: return old;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(input int i);
        if (i >= 19) return 64'h0;
        if (i == 16) return {mdl[16][63:32], bcyc};
        return mdl[i];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check read now, update model at edge,
    // check err and pulses at the next negedge.
    task automatic op(input logic re, input int ri, input logic we, input int wi,
                      input logic [63:0] wd, input logic sp, input string req);
        @(negedge clk);
        rd_en = re; rd_idx = 6'(ri); wr_en = we; wr_idx = 6'(wi); wr_data = wd; spec = sp;
        #1;
        if (re) check({req, " rd"}, rd_data, exp_read(ri));
        exp_err   = (re && rd_is_bad(ri)) || (we && !sp && wr_is_bad(wi));
        exp_pulse = 2'b00;
        if (we && !sp && (wi == 19 || wi == 20)) exp_pulse[wi - 19] = 1'b1;
        @(posedge clk);
        if (we && !sp && !wr_is_bad(wi) && wi <= 17) mdl[wi] = after_write(wi, wd, mdl[wi]);
        @(negedge clk);
        check({req, " R9 err"}, 64'(err), 64'(exp_err));
        check({req, " R10 pulse"}, 64'(cmd_pulse), 64'(exp_pulse));
        rd_en = 1'b0; wr_en = 1'b0; spec = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i <= 20; i++) mdl[i] = reset_val(i);
        repeat (3) @(negedge clk);
        rd_en = 1'b1; rd_idx = 6'd5; #1;
        check("R1 memctl in reset", rd_data, 64'h6);
        rd_en = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values of all indices
        for (int i = 0; i <= 20; i++) op(1'b1, i, 1'b0, 0, 64'h0, 1'b0, "R1 reset");
        // R3: exception address drops bit 1
        op(1'b0, 0, 1'b1, 6, '1, 1'b0, "R3 wr");
        op(1'b1, 6, 1'b0, 0, 64'h0, 1'b0, "R3");
        // R4: field masks
        op(1'b0, 0, 1'b1, 9, '1, 1'b0, "R4 wr");
        op(1'b1, 9, 1'b1, 11, '1, 1'b0, "R4");
        op(1'b1, 11, 1'b0, 0, 64'h0, 1'b0, "R4");
        // R5: clear on write
        op(1'b1, 14, 1'b1, 14, '1, 1'b0, "R5");
        op(1'b1, 14, 1'b0, 0, 64'h0, 1'b0, "R5");
        // R6: counter upper stored, lower live
        op(1'b0, 0, 1'b1, 16, 64'hDEAD_BEEF_1234_5678, 1'b0, "R6 wr");
        op(1'b1, 16, 1'b0, 0, 64'h0, 1'b0, "R6");
        // R7: write-once lock
        op(1'b1, 17, 1'b1, 17, 64'h55, 1'b0, "R7 first");
        op(1'b1, 17, 1'b1, 17, 64'h0, 1'b0, "R7 second");
        // R8: speculation suppresses writes and pulses
        op(1'b0, 0, 1'b1, 0, 64'hAAAA, 1'b1, "R8 spec");
        op(1'b1, 0, 1'b1, 19, 64'h1, 1'b1, "R8 spec cmd");
        // R9: bad accesses
        op(1'b1, 63, 1'b0, 0, 64'h0, 1'b0, "R9 invalid rd");
        op(1'b0, 0, 1'b1, 18, '1, 1'b0, "R9 ro wr");
        op(1'b1, 20, 1'b0, 0, 64'h0, 1'b0, "R9 cmd rd");
        // R10: command pulses
        op(1'b0, 0, 1'b1, 19, 64'h0, 1'b0, "R10 cmd0");
        op(1'b0, 0, 1'b1, 20, 64'h0, 1'b0, "R10 cmd1");
        // R2 and all rules: random mix
        for (int n = 0; n < 600; n++) begin
            int ri, wi;
            ri = ($urandom_range(0, 15) == 0) ? 6'($urandom) : $urandom_range(0, 20);
            wi = ($urandom_range(0, 15) == 0) ? 6'($urandom) : $urandom_range(0, 20);
            op(1'($urandom), ri, 1'($urandom), wi, {$urandom, $urandom},
               ($urandom_range(0, 7) == 0), "R2 random");
        end
        // R7: lock releases on reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i <= 20; i++) mdl[i] = reset_val(i);
        op(1'b1, 17, 1'b1, 17, 64'h3, 1'b0, "R7 after reset");
        op(1'b1, 17, 1'b0, 0, 64'h0, 1'b0, "R7 after reset");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule